// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block collects interrupt requests from three kinds of source and hands each one to one or more of four CPUs. The sources are level-sensitive hardware lines, a timer line and a watchdog line private to each CPU, and software-generated inter-processor requests. There are 64 interrupt IDs. Every ID has its own enable and 4-bit priority, and every shared hardware ID also has a CPU target mask. The state of each ID (inactive, pending or active) is held separately for every CPU, so a CPU can finish an interrupt while another CPU is still working on it.

Software drives a single write port. This port sets the per-ID settings, each CPU's priority mask and software interrupt requests. Each CPU has its own handshake. An interrupt line tells the CPU that an ID is ready to take. An acknowledge strobe takes the best ID and returns its number. A completion strobe with an ID ends the handling of that ID.

Top module: `irq_distributor`

## Requirements
- R1: After reset no `cpu_irq` bit is set and every `ack_id` lane reads 1023.
- R2: A write to address 0x40 with mode field `cfg_wdata[5:4]`=0 makes the software ID in `cfg_wdata[3:0]` pending on exactly the CPUs whose bits are set in `cfg_wdata[11:8]`.
- R3: Mode 1 at address 0x40 sends the software ID to every CPU except `cfg_cpu`. Mode 2 sends it only to `cfg_cpu`.
- R4: IDs 0..31 have a separate priority and enable for each CPU, written to address = ID with `cfg_cpu` choosing the CPU (`cfg_wdata[3:0]` priority, bit 4 enable). A software ID therefore ranks by the priority that the receiving CPU holds for it.
- R5: Hardware line `hw_irq[k]` is ID 32+k. It becomes pending only on the CPUs in its target mask, written at address = ID with `cfg_wdata[11:8]` as the mask (bit c is CPU c), priority in bits 3:0 and enable in bit 4.
- R6: Among pending, enabled IDs a CPU takes the lowest priority value first. When priorities are equal, the lower ID goes first.
- R7: A disabled ID is never signalled or acknowledged.
- R8: A CPU is signalled only for a priority value strictly below its mask. The mask is written at address 0x41 (`cfg_wdata[3:0]`, selected by `cfg_cpu`) and resets to 15.
- R9: While IDs are active on a CPU, only a pending ID with a strictly lower priority value than every active one is signalled. Acknowledging it nests it on top of the active ones.
- R10: Completion makes the ID inactive on that CPU. If its level line is still high it becomes pending again.
- R11: `timer_irq[c]` is ID 29 and `wdog_irq[c]` is ID 30, and each reaches only CPU c.
- R12: An acknowledge while the CPU is not signalled returns 1023 and changes no state.
- R13: Completion of an ID that is not active on that CPU, or of an ID of 64 or more, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | 32 | Level hardware lines, bit k is ID 32+k |
| timer_irq | input | 4 | Per-CPU private timer line (ID 29) |
| wdog_irq | input | 4 | Per-CPU private watchdog line (ID 30) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | 0..63 per-ID settings, 0x40 software request, 0x41 priority mask |
| cfg_cpu | input | 2 | Requesting CPU, also the bank for private settings |
| cfg_wdata | input | 16 | Write data |
| ack_req | input | 4 | Per-CPU acknowledge strobe |
| ack_id | output | 40 | Per-CPU acknowledged ID, 10 bits per CPU, valid the cycle after the strobe |
| eoi_we | input | 4 | Per-CPU completion strobe |
| eoi_id | input | 40 | Per-CPU completed ID, 10 bits per CPU |
| cpu_irq | output | 4 | Per-CPU interrupt signal |

## Verification
Software requests are sent in all three routing modes from different requesting CPUs, which tells list routing apart from all-but-self and self-only. The same software IDs get opposite priorities on two CPUs, which shows that the ranking comes from the receiver. Hardware lines are raised with partial target masks, and then disabled, masked (at and just above the threshold) and stacked into nested preemption. This separates the enable, mask and running-priority gates. Equal-priority pending IDs check the tie rule. Completions are issued with lines still high, for IDs that are not active, and for IDs out of range, which tests re-pending against no effect.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int unsigned ID_BITS     = 10;
   localparam logic [ID_BITS-1:0] NO_IRQ = 10'd1023;
   localparam int unsigned ADDR_BITS   = 7;
   localparam int unsigned DATA_BITS   = 16;
   localparam logic [ADDR_BITS-1:0] ADDR_SWREQ = 7'h40;
   localparam logic [ADDR_BITS-1:0] ADDR_PMASK = 7'h41;
   localparam int unsigned TGT_LSB     = 8;

   typedef enum logic [1:0] {
      SW_LIST   = 2'd0,
      SW_OTHERS = 2'd1,
      SW_SELF   = 2'd2
   } sw_route_e;
endpackage

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int unsigned NID    = 64,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IW    = $clog2(NID)
) (
   input  logic [NID-1:0]             cand_i,
   input  logic [NID-1:0][PRIO_W-1:0] prio_i,
   output logic                       found_o,
   output logic [IW-1:0]              id_o,
   output logic [PRIO_W-1:0]          prio_o
);
   // ascending scan with strict compare: equal priority keeps lower ID
   always_comb begin
      found_o = 1'b0;
      id_o    = '0;
      prio_o  = '1;
      for (int i = 0; i < NID; i++) begin
         if (cand_i[i] && (!found_o || prio_i[i] < prio_o)) begin
            found_o = 1'b1;
            id_o    = IW'(i);
            prio_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/irqd_cfg.sv
module irqd_cfg
   import irqd_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned NID    = 64,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned PRIV_N = 32,
   parameter int unsigned SGI_N  = 16,
   localparam int unsigned CPU_W = $clog2(NCPU),
   localparam int unsigned NHW   = NID - PRIV_N
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [ADDR_BITS-1:0]                cfg_addr,
   input  logic [CPU_W-1:0]                    cfg_cpu,
   input  logic [DATA_BITS-1:0]                cfg_wdata,
   output logic [NCPU-1:0][NID-1:0][PRIO_W-1:0] prio_o,
   output logic [NCPU-1:0][NID-1:0]            en_o,
   output logic [NCPU-1:0][NID-1:0]            route_o,
   output logic [NCPU-1:0][PRIO_W-1:0]         pmask_o,
   output logic [NCPU-1:0][SGI_N-1:0]          sgi_o
);
   localparam int unsigned PW  = $clog2(PRIV_N);
   localparam int unsigned HWW = (NHW > 1) ? $clog2(NHW) : 1;
   localparam int unsigned SW  = $clog2(SGI_N);

   logic [NCPU-1:0][PRIV_N-1:0][PRIO_W-1:0] bprio_q;
   logic [NCPU-1:0][PRIV_N-1:0]             ben_q;
   logic [NHW-1:0][PRIO_W-1:0]              sprio_q;
   logic [NHW-1:0]                          sen_q;
   logic [NHW-1:0][NCPU-1:0]                stgt_q;
   logic [NCPU-1:0][PRIO_W-1:0]             pmask_q;

   logic [ADDR_BITS-1:0] hw_off;
   logic                 is_priv, is_shared, sw_hit;
   logic [NCPU-1:0]      self_oh, sw_dest;
   sw_route_e            sw_mode;

   assign hw_off    = cfg_addr - ADDR_BITS'(PRIV_N);
   assign is_priv   = cfg_addr < ADDR_BITS'(PRIV_N);
   assign is_shared = !is_priv && cfg_addr < ADDR_BITS'(NID);
   assign sw_hit    = cfg_we && cfg_addr == ADDR_SWREQ;
   assign self_oh   = NCPU'(1) << cfg_cpu;
   assign sw_mode   = sw_route_e'(cfg_wdata[SW+1:SW]);

   always_comb begin
      unique case (sw_mode)
         SW_LIST:   sw_dest = cfg_wdata[TGT_LSB +: NCPU];
         SW_OTHERS: sw_dest = ~self_oh;
         SW_SELF:   sw_dest = self_oh;
         default:   sw_dest = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bprio_q <= '0;
         ben_q   <= '0;
         sprio_q <= '0;
         sen_q   <= '0;
         stgt_q  <= '0;
         pmask_q <= '1;
      end else if (cfg_we) begin
         if (is_priv) begin
            bprio_q[cfg_cpu][cfg_addr[PW-1:0]] <= cfg_wdata[PRIO_W-1:0];
            ben_q[cfg_cpu][cfg_addr[PW-1:0]]   <= cfg_wdata[PRIO_W];
         end else if (is_shared) begin
            sprio_q[hw_off[HWW-1:0]] <= cfg_wdata[PRIO_W-1:0];
            sen_q[hw_off[HWW-1:0]]   <= cfg_wdata[PRIO_W];
            stgt_q[hw_off[HWW-1:0]]  <= cfg_wdata[TGT_LSB +: NCPU];
         end else if (cfg_addr == ADDR_PMASK) begin
            pmask_q[cfg_cpu] <= cfg_wdata[PRIO_W-1:0];
         end
      end
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign pmask_o[c] = pmask_q[c];
      for (genvar s = 0; s < SGI_N; s++) begin : g_sgi
         assign sgi_o[c][s] = sw_hit && sw_dest[c] && cfg_wdata[SW-1:0] == SW'(s);
      end
      for (genvar i = 0; i < NID; i++) begin : g_id
         if (i < PRIV_N) begin : g_banked
            assign prio_o[c][i]  = bprio_q[c][i];
            assign en_o[c][i]    = ben_q[c][i];
            assign route_o[c][i] = 1'b1;
         end else begin : g_shared
            assign prio_o[c][i]  = sprio_q[i-PRIV_N];
            assign en_o[c][i]    = sen_q[i-PRIV_N];
            assign route_o[c][i] = stgt_q[i-PRIV_N][c];
         end
      end
   end

   // R3: all-but-self never reaches the requester
   a_r3_others_skip_self: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit && sw_mode == SW_OTHERS) |-> !sw_dest[cfg_cpu]);
   // R3: self-only reaches exactly one CPU
   a_r3_self_single: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit && sw_mode == SW_SELF) |-> $countones(sw_dest) == 1);
endmodule

// File: rtl/irqd_cpu.sv
module irqd_cpu
   import irqd_pkg::*;
#(
   parameter int unsigned NID      = 64,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned PRIV_N   = 32,
   parameter int unsigned SGI_N    = 16,
   parameter int unsigned TIMER_ID = 29,
   parameter int unsigned WDOG_ID  = 30,
   localparam int unsigned NHW     = NID - PRIV_N,
   localparam int unsigned IW      = $clog2(NID)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NID-1:0][PRIO_W-1:0] prio_i,
   input  logic [NID-1:0]             en_i,
   input  logic [NID-1:0]             route_i,
   input  logic [PRIO_W-1:0]          pmask_i,
   input  logic [SGI_N-1:0]           sgi_set_i,
   input  logic [NHW-1:0]             hw_i,
   input  logic                       timer_i,
   input  logic                       wdog_i,
   input  logic                       ack_req_i,
   output logic [ID_BITS-1:0]         ack_id_o,
   input  logic                       eoi_we_i,
   input  logic [ID_BITS-1:0]         eoi_id_i,
   output logic                       irq_o
);
   logic [SGI_N-1:0] sgi_pend_q;
   logic [NID-1:0]   active_q, pend, cand, set_vec, clr_vec;
   logic             p_found, a_found;
   logic [IW-1:0]    p_id, a_id;
   logic [PRIO_W-1:0] p_prio, a_prio;
   logic [PRIO_W:0]  run_prio;

   // pending per ID: latched for software, derived from level for the rest
   for (genvar i = 0; i < NID; i++) begin : g_pend
      if (i < SGI_N) begin : g_sw
         assign pend[i] = sgi_pend_q[i];
      end else if (i == TIMER_ID) begin : g_tmr
         assign pend[i] = timer_i & ~active_q[i];
      end else if (i == WDOG_ID) begin : g_wdg
         assign pend[i] = wdog_i & ~active_q[i];
      end else if (i >= PRIV_N) begin : g_hw
         assign pend[i] = hw_i[i-PRIV_N] & route_i[i] & ~active_q[i];
      end else begin : g_rsvd
         assign pend[i] = 1'b0;
      end
   end

   assign cand = pend & en_i;

   irqd_pick #(.NID(NID), .PRIO_W(PRIO_W)) i_pick_pend (
      .cand_i(cand), .prio_i(prio_i),
      .found_o(p_found), .id_o(p_id), .prio_o(p_prio));

   irqd_pick #(.NID(NID), .PRIO_W(PRIO_W)) i_pick_run (
      .cand_i(active_q), .prio_i(prio_i),
      .found_o(a_found), .id_o(a_id), .prio_o(a_prio));

   assign run_prio = a_found ? {1'b0, a_prio} : {1'b1, {PRIO_W{1'b0}}};
   assign irq_o    = p_found && ({1'b0, p_prio} < run_prio) && (p_prio < pmask_i);

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      if (ack_req_i && irq_o) set_vec[p_id] = 1'b1;
      if (eoi_we_i && eoi_id_i < ID_BITS'(NID)) clr_vec[eoi_id_i[IW-1:0]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sgi_pend_q <= '0;
         active_q   <= '0;
         ack_id_o   <= NO_IRQ;
      end else begin
         sgi_pend_q <= (sgi_pend_q & ~set_vec[SGI_N-1:0]) | sgi_set_i;
         active_q   <= (active_q | set_vec) & ~clr_vec;
         if (ack_req_i) ack_id_o <= irq_o ? ID_BITS'(p_id) : NO_IRQ;
      end
   end

   // R12: an unsignalled acknowledge returns the empty code and moves nothing
   a_r12_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req_i && !irq_o && !eoi_we_i) |=> (ack_id_o == NO_IRQ && $stable(active_q)));
   // R9: an acknowledged ID is active afterwards
   a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req_i && irq_o && !eoi_we_i) |=> active_q[ack_id_o[IW-1:0]]);
   // R10: completion leaves the ID inactive
   a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_we_i && eoi_id_i < ID_BITS'(NID)) |=> !active_q[$past(eoi_id_i[IW-1:0])]);
   // R6: the returned ID is always a real ID or the empty code
   a_r6_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_id_o == NO_IRQ) || (ack_id_o < ID_BITS'(NID)));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irqd_pkg::*;
#(
   parameter int unsigned NCPU     = 4,
   parameter int unsigned NID      = 64,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned PRIV_N   = 32,
   parameter int unsigned SGI_N    = 16,
   parameter int unsigned TIMER_ID = 29,
   parameter int unsigned WDOG_ID  = 30
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NID-PRIV_N-1:0]       hw_irq,
   input  logic [NCPU-1:0]             timer_irq,
   input  logic [NCPU-1:0]             wdog_irq,
   input  logic                        cfg_we,
   input  logic [ADDR_BITS-1:0]        cfg_addr,
   input  logic [$clog2(NCPU)-1:0]     cfg_cpu,
   input  logic [DATA_BITS-1:0]        cfg_wdata,
   input  logic [NCPU-1:0]             ack_req,
   output logic [NCPU*ID_BITS-1:0]     ack_id,
   input  logic [NCPU-1:0]             eoi_we,
   input  logic [NCPU*ID_BITS-1:0]     eoi_id,
   output logic [NCPU-1:0]             cpu_irq
);
   if (NCPU < 2 || TGT_LSB + NCPU > DATA_BITS) begin : g_bad_ncpu
      $error("irq_distributor: NCPU must fit the target field");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("irq_distributor: PRIO_W must be 1..4");
   end
   if (NID > 64 || NID < PRIV_N + 2) begin : g_bad_nid
      $error("irq_distributor: NID must leave shared IDs and fit below 0x40");
   end
   if (SGI_N < 2 || SGI_N > 16 || TIMER_ID < SGI_N || WDOG_ID < SGI_N ||
       TIMER_ID >= PRIV_N || WDOG_ID >= PRIV_N || TIMER_ID == WDOG_ID) begin : g_bad_priv
      $error("irq_distributor: private ID layout inconsistent");
   end

   logic [NCPU-1:0][NID-1:0][PRIO_W-1:0] prio;
   logic [NCPU-1:0][NID-1:0]             en, route;
   logic [NCPU-1:0][PRIO_W-1:0]          pmask;
   logic [NCPU-1:0][SGI_N-1:0]           sgi;

   irqd_cfg #(.NCPU(NCPU), .NID(NID), .PRIO_W(PRIO_W), .PRIV_N(PRIV_N), .SGI_N(SGI_N)) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_cpu(cfg_cpu), .cfg_wdata(cfg_wdata),
      .prio_o(prio), .en_o(en), .route_o(route), .pmask_o(pmask), .sgi_o(sgi));

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      irqd_cpu #(.NID(NID), .PRIO_W(PRIO_W), .PRIV_N(PRIV_N), .SGI_N(SGI_N),
                 .TIMER_ID(TIMER_ID), .WDOG_ID(WDOG_ID)) i_cpu (
         .clk(clk), .rst_n(rst_n),
         .prio_i(prio[c]), .en_i(en[c]), .route_i(route[c]), .pmask_i(pmask[c]),
         .sgi_set_i(sgi[c]), .hw_i(hw_irq),
         .timer_i(timer_irq[c]), .wdog_i(wdog_irq[c]),
         .ack_req_i(ack_req[c]), .ack_id_o(ack_id[c*ID_BITS +: ID_BITS]),
         .eoi_we_i(eoi_we[c]), .eoi_id_i(eoi_id[c*ID_BITS +: ID_BITS]),
         .irq_o(cpu_irq[c]));
   end

   // R1: nothing signalled in the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> cpu_irq == '0);
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hw_irq = '0;
   logic [3:0]  timer_irq = '0, wdog_irq = '0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [1:0]  cfg_cpu = '0;
   logic [15:0] cfg_wdata = '0;
   logic [3:0]  ack_req = '0;
   logic [39:0] ack_id;
   logic [3:0]  eoi_we = '0;
   logic [39:0] eoi_id = '0;
   logic [3:0]  cpu_irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_distributor i_irq_distributor (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .timer_irq(timer_irq),
      .wdog_irq(wdog_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_cpu(cfg_cpu),
      .cfg_wdata(cfg_wdata), .ack_req(ack_req), .ack_id(ack_id),
      .eoi_we(eoi_we), .eoi_id(eoi_id), .cpu_irq(cpu_irq));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_irq(input logic [3:0] exp, input string req);
      check(cpu_irq == exp, req, cpu_irq, exp);
   endtask

   task automatic wr(input int cpu, input int addr, input logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cpu = 2'(cpu); cfg_addr = 7'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_priv(input int cpu, input int id, input int prio, input bit en);
      wr(cpu, id, {11'b0, en, 4'(prio)});
   endtask

   task automatic set_shared(input int id, input int prio, input bit en, input logic [3:0] tgt);
      wr(0, id, {4'b0, tgt, 3'b0, en, 4'(prio)});
   endtask

   task automatic sw_req(input int from, input int id, input int mode, input logic [3:0] lst);
      wr(from, 'h40, {4'b0, lst, 2'b0, 2'(mode), 4'(id)});
   endtask

   task automatic ack(input int cpu, input int exp, input string req);
      @(negedge clk);
      ack_req[cpu] = 1'b1;
      @(negedge clk);
      ack_req[cpu] = 1'b0;
      check(ack_id[cpu*10 +: 10] == 10'(exp), req, ack_id[cpu*10 +: 10], exp);
   endtask

   task automatic eoi(input int cpu, input int id);
      @(negedge clk);
      eoi_we[cpu] = 1'b1; eoi_id[cpu*10 +: 10] = 10'(id);
      @(negedge clk);
      eoi_we[cpu] = 1'b0;
   endtask

   task automatic t_reset;
      check_irq(4'b0000, "R1 irq after reset");
      for (int c = 0; c < 4; c++)
         check(ack_id[c*10 +: 10] == 10'd1023, "R1 ack lane reset", ack_id[c*10 +: 10], 1023);
      ack(0, 1023, "R12 empty ack");
      check_irq(4'b0000, "R12 no state change");
   endtask

   task automatic t_sw_list;
      for (int c = 0; c < 4; c++) set_priv(c, 3, 5, 1'b1);
      sw_req(0, 3, 0, 4'b0110);
      check_irq(4'b0110, "R2 list routing");
      ack(1, 3, "R2 cpu1 ack");
      ack(2, 3, "R2 cpu2 ack");
      eoi(1, 3); eoi(2, 3);
      check_irq(4'b0000, "R2 after completion");
   endtask

   task automatic t_sw_modes;
      sw_req(2, 3, 1, 4'b0000);
      check_irq(4'b1011, "R3 all but self");
      for (int c = 0; c < 4; c++) if (c != 2) begin ack(c, 3, "R3 others ack"); eoi(c, 3); end
      sw_req(1, 3, 2, 4'b1111);
      check_irq(4'b0010, "R3 self only");
      ack(1, 3, "R3 self ack"); eoi(1, 3);
      check_irq(4'b0000, "R3 drained");
   endtask

   task automatic t_sw_prio;
      set_priv(0, 1, 2, 1'b1); set_priv(0, 0, 8, 1'b1);
      set_priv(1, 1, 8, 1'b1); set_priv(1, 0, 2, 1'b1);
      sw_req(3, 0, 0, 4'b0011);
      sw_req(3, 1, 0, 4'b0011);
      ack(0, 1, "R4 cpu0 ranks by own priority");
      ack(1, 0, "R4 cpu1 ranks by own priority");
      eoi(0, 1); ack(0, 0, "R4 cpu0 second"); eoi(0, 0);
      eoi(1, 0); ack(1, 1, "R4 cpu1 second"); eoi(1, 1);
      check_irq(4'b0000, "R4 drained");
   endtask

   task automatic t_tie;
      set_priv(0, 0, 9, 1'b1); set_priv(0, 1, 6, 1'b1); set_priv(0, 2, 6, 1'b1);
      sw_req(0, 2, 2, 4'b0); sw_req(0, 0, 2, 4'b0); sw_req(0, 1, 2, 4'b0);
      ack(0, 1, "R6 tie goes to lower ID");
      eoi(0, 1); ack(0, 2, "R6 next equal priority");
      eoi(0, 2); ack(0, 0, "R6 worst priority last");
      eoi(0, 0);
   endtask

   task automatic t_hw_route;
      set_shared(40, 4, 1'b1, 4'b0101);
      @(negedge clk); hw_irq[8] = 1'b1;
      @(negedge clk);
      check_irq(4'b0101, "R5 target mask");
      ack(0, 40, "R5 cpu0 ack");
      check_irq(4'b0100, "R5 active on cpu0 only");
      eoi(0, 40);
      check_irq(4'b0101, "R10 line high re-pends");
      @(negedge clk); hw_irq[8] = 1'b0;
      @(negedge clk);
      check_irq(4'b0000, "R10 line low");
   endtask

   task automatic t_enable;
      set_shared(45, 3, 1'b0, 4'b0001);
      @(negedge clk); hw_irq[13] = 1'b1;
      @(negedge clk);
      check_irq(4'b0000, "R7 disabled not signalled");
      ack(0, 1023, "R7 disabled not acked");
      set_shared(45, 3, 1'b1, 4'b0001);
      check_irq(4'b0001, "R7 enabled signals");
   endtask

   task automatic t_pmask;
      wr(0, 'h41, 16'd3);
      check_irq(4'b0000, "R8 equal to mask blocked");
      ack(0, 1023, "R8 masked ack empty");
      wr(0, 'h41, 16'd4);
      check_irq(4'b0001, "R8 below mask passes");
      wr(0, 'h41, 16'd15);
      @(negedge clk); hw_irq[13] = 1'b0;
      @(negedge clk);
      check_irq(4'b0000, "R8 cleared");
   endtask

   task automatic t_preempt;
      set_shared(50, 6, 1'b1, 4'b0001);
      set_shared(51, 2, 1'b1, 4'b0001);
      set_shared(52, 6, 1'b1, 4'b0001);
      @(negedge clk); hw_irq[18] = 1'b1;
      ack(0, 50, "R9 first");
      @(negedge clk); hw_irq[20] = 1'b1;
      @(negedge clk);
      check_irq(4'b0000, "R9 equal priority does not preempt");
      hw_irq[19] = 1'b1;
      @(negedge clk);
      check_irq(4'b0001, "R9 higher priority preempts");
      ack(0, 51, "R9 nested ack");
      check_irq(4'b0000, "R9 nothing above nested");
      hw_irq[19] = 1'b0;
      eoi(0, 51);
      check_irq(4'b0000, "R9 outer still blocks equal");
      hw_irq[18] = 1'b0;
      eoi(0, 50);
      check_irq(4'b0001, "R9 equal after outer done");
      ack(0, 52, "R9 last");
      hw_irq[20] = 1'b0;
      eoi(0, 52);
      check_irq(4'b0000, "R9 drained");
   endtask

   task automatic t_private_lines;
      set_priv(1, 29, 1, 1'b1); set_priv(2, 29, 1, 1'b1); set_priv(3, 30, 1, 1'b1);
      @(negedge clk); timer_irq[1] = 1'b1;
      @(negedge clk);
      check_irq(4'b0010, "R11 timer reaches own CPU only");
      wdog_irq[3] = 1'b1;
      @(negedge clk);
      check_irq(4'b1010, "R11 watchdog own CPU");
      ack(3, 30, "R11 watchdog ID");
      ack(1, 29, "R11 timer ID");
      timer_irq[1] = 1'b0; wdog_irq[3] = 1'b0;
      eoi(3, 30); eoi(1, 29);
      check_irq(4'b0000, "R11 drained");
   endtask

   task automatic t_eoi_noeffect;
      set_priv(0, 2, 6, 1'b1);
      sw_req(0, 3, 2, 4'b0);
      ack(0, 3, "R13 setup");
      sw_req(0, 2, 2, 4'b0);
      check_irq(4'b0000, "R13 lower priority held back");
      eoi(0, 9);
      check_irq(4'b0000, "R13 non-active completion ignored");
      eoi(0, 100);
      check_irq(4'b0000, "R13 out of range completion ignored");
      eoi(0, 3);
      check_irq(4'b0001, "R13 real completion");
      ack(0, 2, "R13 follow-on");
      eoi(0, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_list();
      t_sw_modes();
      t_sw_prio();
      t_tie();
      t_hw_route();
      t_enable();
      t_pmask();
      t_preempt();
      t_private_lines();
      t_eoi_noeffect();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule